// File: doc/BRIEF.md
# Bus Line State Event Detector

This block sits behind the two single-ended receivers of a two-wire differential serial bus, such as USB at low or full speed. It resynchronizes both line levels and classifies every sample as J, K, single-ended zero (SE0) or the forbidden both-high state (SE1). Which wire carries J is set by a speed-select input. At full speed, J is D+ high. At low speed, J is D- high.

From how long each line state lasts, the block derives protocol-level events:

- **Connect**: a device attaching.
- **End-of-packet**: a packet closing.
- **Keep-alive**: at low speed, a bare end-of-packet with no packet in front of it.
- **Bus reset**: a long SE0.
- **Suspend**: entered after a long idle period.
- **Resume**: a long K followed by an end-of-packet, which leaves suspend.

Every duration is a parameter counted in clock cycles. The bus-reset threshold is a fixed cycle count and does not depend on the speed setting. The bit-time parameters are separate for the two speeds.

The outputs are the decoded line state, an SE1 error level, a suspend level, and single-cycle event pulses. These pulses feed a packet engine and a power controller.

Top module: `bus_line_monitor`

## Requirements
- R1: `lineState` encodes SE0 as 2'b00, J as 2'b01, K as 2'b10 and SE1 as 2'b11. J means D+ high and D- low when `lowSpeed` is 0, and D- high and D+ low when `lowSpeed` is 1. K is the opposite pair. `lineState` follows the pins two clock cycles late.
- R2: `se1Err` is high exactly while `lineState` shows both lines high.
- R3: While not yet connected, J held for `CONN_CYC` cycles raises `connectEvt` for one cycle. It never fires again.
- R4: An SE0 lasting from one to three bit times, followed by J for at least one bit time, gives one `eopEvt`. The bit time is `FS_BIT_CYC` or `LS_BIT_CYC`, chosen by `lowSpeed`.
- R5: At low speed, an end-of-packet whose SE0 came straight out of at least 8 bit times of J is a keep-alive. It raises `keepAliveEvt` instead of `eopEvt`. At full speed the same pattern gives `eopEvt`.
- R6: SE0 reaching `RESET_CYC` cycles gives one `busResetEvt` at either speed, and clears suspend.
- R7: After connection, `IDLE_CYC` cycles of uninterrupted J set `suspendOut`. It stays set until a resume or a bus reset.
- R8: While suspended, K held for at least `RESUME_CYC` cycles, then SE0, then J gives one `resumeEvt` and clears `suspendOut`. That end-of-packet is not also reported as `eopEvt`.
- R9: While suspended, a K shorter than `RESUME_CYC` does not resume and leaves `suspendOut` set.
- R10: Each event output is a single-cycle pulse. At most one of `eopEvt`, `keepAliveEvt`, `busResetEvt` and `resumeEvt` is high in any cycle.
- R11: An SE0 shorter than one bit time, or an end-of-packet whose trailing J lasts less than one bit time, produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dpIn | input | 1 | Raw D+ receiver level |
| dmIn | input | 1 | Raw D- receiver level |
| lowSpeed | input | 1 | 1 = low-speed polarity and bit time |
| lineState | output | 2 | Decoded line state |
| se1Err | output | 1 | Both lines high |
| connectEvt | output | 1 | Attach pulse |
| eopEvt | output | 1 | End-of-packet pulse |
| keepAliveEvt | output | 1 | Low-speed keep-alive pulse |
| busResetEvt | output | 1 | Bus reset pulse |
| suspendOut | output | 1 | Suspended level |
| resumeEvt | output | 1 | Resume pulse |

## Verification
The bench builds the block with these parameters:

| Parameter | Value |
|---|---|
| `FS_BIT_CYC` | 4 |
| `LS_BIT_CYC` | 16 |
| `CONN_CYC` | 20 |
| `RESET_CYC` | 100 |
| `RESUME_CYC` | 200 |
| `IDLE_CYC` | 300 |

With the thresholds shortened this far, one run of a few thousand cycles covers the whole sequence: attach, packets and bare end-of-packets at both speeds, bus reset, entry into suspend, a rejected short K, a real resume, and a reset out of suspend. The low and full bit times differ by a factor of four. A wrong speed selection therefore moves the end-of-packet window and the keep-alive gap far enough to change which event appears.

// File: rtl/blm_pkg.sv
package blm_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } lineSt_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic idleClr;
    logic idleHold;
  } dpCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/blm_datapath.sv
module blm_datapath
  import blm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_W       = 8,
  parameter int IDLE_CYC    = 300
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dpIn,
  input  logic             dmIn,
  input  logic             lowSpeed,
  input  dpCtl_t           ctl,
  output lineSt_t          curSt,
  output lineSt_t          stReg,
  output logic [RUN_W-1:0] runCnt,
  output logic             idleExpired
);

  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [IDLE_W-1:0] IDLE_V = IDLE_W'(IDLE_CYC);

  logic [1:0] rawLine;
  logic [1:0] syncLine;
  assign rawLine = {dpIn, dmIn};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawLine[g]};
      end
      assign syncLine[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  // classify synchronized pair {D+, D-}
  always_comb begin
    unique case (syncLine)
      2'b00:   curSt = LS_SE0;
      2'b11:   curSt = LS_SE1;
      2'b10:   curSt = lowSpeed ? LS_K : LS_J;
      default: curSt = lowSpeed ? LS_J : LS_K;
    endcase
  end

  // run-length of the current state, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stReg  <= LS_SE0;
      runCnt <= '0;
    end else begin
      stReg <= curSt;
      if (curSt != stReg)   runCnt <= RUN_W'(1);
      else if (runCnt != '1) runCnt <= runCnt + RUN_W'(1);
    end
  end

  // inactivity timer
  logic [IDLE_W-1:0] idleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 idleCnt <= '0;
    else if (ctl.idleClr)      idleCnt <= '0;
    else if (!ctl.idleHold && idleCnt != IDLE_V)
                               idleCnt <= idleCnt + IDLE_W'(1);
  end
  assign idleExpired = (idleCnt == IDLE_V);

  p_idle_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_V);

  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idleClr |=> idleCnt == '0);

endmodule

// File: rtl/blm_control.sv
module blm_control
  import blm_pkg::*;
#(
  parameter int RUN_W       = 8,
  parameter int FS_BIT_CYC  = 4,
  parameter int LS_BIT_CYC  = 32,
  parameter int CONN_CYC    = 120,
  parameter int RESET_CYC   = 120,
  parameter int RESUME_CYC  = 960000,
  parameter int KA_GAP_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowSpeed,
  input  lineSt_t          curSt,
  input  lineSt_t          stReg,
  input  logic [RUN_W-1:0] runCnt,
  input  logic             idleExpired,
  output dpCtl_t           ctl,
  output logic             connectEvt,
  output logic             eopEvt,
  output logic             keepAliveEvt,
  output logic             busResetEvt,
  output logic             resumeEvt,
  output logic             suspended
);

  localparam logic [RUN_W-1:0] FS_BIT_V  = RUN_W'(FS_BIT_CYC);
  localparam logic [RUN_W-1:0] LS_BIT_V  = RUN_W'(LS_BIT_CYC);
  localparam logic [RUN_W-1:0] FS_MAX_V  = RUN_W'(3 * FS_BIT_CYC);
  localparam logic [RUN_W-1:0] LS_MAX_V  = RUN_W'(3 * LS_BIT_CYC);
  localparam logic [RUN_W-1:0] FS_GAP_V  = RUN_W'(KA_GAP_BITS * FS_BIT_CYC);
  localparam logic [RUN_W-1:0] LS_GAP_V  = RUN_W'(KA_GAP_BITS * LS_BIT_CYC);
  localparam logic [RUN_W-1:0] CONN_V    = RUN_W'(CONN_CYC);
  localparam logic [RUN_W-1:0] RESET_V   = RUN_W'(RESET_CYC);
  localparam logic [RUN_W-1:0] RESUME_V  = RUN_W'(RESUME_CYC);

  logic [RUN_W-1:0] bitV, eopMaxV, gapV;
  logic chg, se0End, eopWindow;
  logic connected, eopPend, eopBare, preJLong, resumeArm;

  assign bitV    = lowSpeed ? LS_BIT_V : FS_BIT_V;
  assign eopMaxV = lowSpeed ? LS_MAX_V : FS_MAX_V;
  assign gapV    = lowSpeed ? LS_GAP_V : FS_GAP_V;

  assign chg       = (curSt != stReg);
  assign se0End    = chg && (stReg == LS_SE0);
  assign eopWindow = (runCnt >= bitV) && (runCnt <= eopMaxV);

  assign ctl.idleClr  = (curSt != LS_J);
  assign ctl.idleHold = suspended || !connected;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      connected    <= 1'b0;
      suspended    <= 1'b0;
      eopPend      <= 1'b0;
      eopBare      <= 1'b0;
      preJLong     <= 1'b0;
      resumeArm    <= 1'b0;
      connectEvt   <= 1'b0;
      eopEvt       <= 1'b0;
      keepAliveEvt <= 1'b0;
      busResetEvt  <= 1'b0;
      resumeEvt    <= 1'b0;
    end else begin
      connectEvt   <= 1'b0;
      eopEvt       <= 1'b0;
      keepAliveEvt <= 1'b0;
      busResetEvt  <= 1'b0;
      resumeEvt    <= 1'b0;

      // attach
      if (!connected && stReg == LS_J && runCnt == CONN_V) begin
        connected  <= 1'b1;
        connectEvt <= 1'b1;
      end

      // remember whether SE0 was entered straight from a long idle J
      if (chg && curSt == LS_SE0)
        preJLong <= (stReg == LS_J) && (runCnt >= gapV);

      // end-of-packet: arm on SE0->J, fire after one bit of J
      if (se0End && curSt == LS_J && !resumeArm && eopWindow) begin
        eopPend <= 1'b1;
        eopBare <= lowSpeed && preJLong;
      end else if (eopPend && stReg == LS_J && runCnt == bitV) begin
        eopPend <= 1'b0;
        if (eopBare) keepAliveEvt <= 1'b1;
        else         eopEvt       <= 1'b1;
      end else if (eopPend && chg) begin
        eopPend <= 1'b0;
      end

      // resume: long K, then SE0, then J
      if (suspended && chg && stReg == LS_K && curSt == LS_SE0 &&
          runCnt >= RESUME_V) begin
        resumeArm <= 1'b1;
      end else if (resumeArm && se0End) begin
        resumeArm <= 1'b0;
        if (curSt == LS_J) begin
          resumeEvt <= 1'b1;
          suspended <= 1'b0;
        end
      end

      // inactivity
      if (connected && !suspended && idleExpired)
        suspended <= 1'b1;

      // bus reset has the last word
      if (stReg == LS_SE0 && runCnt == RESET_V) begin
        busResetEvt <= 1'b1;
        suspended   <= 1'b0;
        resumeArm   <= 1'b0;
        eopPend     <= 1'b0;
      end
    end
  end

  p_evt_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eopEvt, keepAliveEvt, busResetEvt, resumeEvt}));

  p_eop_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    eopEvt |=> !eopEvt);

  p_conn_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    connectEvt |-> $rose(connected));

  p_reset_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    busResetEvt |-> !suspended);

  p_resume_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    resumeEvt |-> $fell(suspended));

  p_susp_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspended) |-> $past(idleExpired));

endmodule

// File: rtl/bus_line_monitor.sv
module bus_line_monitor
  import blm_pkg::*;
#(
  parameter int FS_BIT_CYC  = 4,
  parameter int LS_BIT_CYC  = 32,
  parameter int CONN_CYC    = 120,
  parameter int RESET_CYC   = 120,
  parameter int IDLE_CYC    = 144000,
  parameter int RESUME_CYC  = 960000,
  parameter int KA_GAP_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dpIn,
  input  logic       dmIn,
  input  logic       lowSpeed,
  output logic [1:0] lineState,
  output logic       se1Err,
  output logic       connectEvt,
  output logic       eopEvt,
  output logic       keepAliveEvt,
  output logic       busResetEvt,
  output logic       suspendOut,
  output logic       resumeEvt
);

  localparam int RUN_MAX = maxOf(maxOf(RESET_CYC, RESUME_CYC),
                                 maxOf(CONN_CYC, maxOf(KA_GAP_BITS, 3) * LS_BIT_CYC)) + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  lineSt_t          curSt, stReg;
  logic [RUN_W-1:0] runCnt;
  logic             idleExpired;
  dpCtl_t           ctl;

  blm_datapath #(
    .SYNC_STAGES(2),
    .RUN_W      (RUN_W),
    .IDLE_CYC   (IDLE_CYC)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .dpIn       (dpIn),
    .dmIn       (dmIn),
    .lowSpeed   (lowSpeed),
    .ctl        (ctl),
    .curSt      (curSt),
    .stReg      (stReg),
    .runCnt     (runCnt),
    .idleExpired(idleExpired)
  );

  blm_control #(
    .RUN_W      (RUN_W),
    .FS_BIT_CYC (FS_BIT_CYC),
    .LS_BIT_CYC (LS_BIT_CYC),
    .CONN_CYC   (CONN_CYC),
    .RESET_CYC  (RESET_CYC),
    .RESUME_CYC (RESUME_CYC),
    .KA_GAP_BITS(KA_GAP_BITS)
  ) ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .lowSpeed    (lowSpeed),
    .curSt       (curSt),
    .stReg       (stReg),
    .runCnt      (runCnt),
    .idleExpired (idleExpired),
    .ctl         (ctl),
    .connectEvt  (connectEvt),
    .eopEvt      (eopEvt),
    .keepAliveEvt(keepAliveEvt),
    .busResetEvt (busResetEvt),
    .resumeEvt   (resumeEvt),
    .suspended   (suspendOut)
  );

  assign lineState = curSt;
  assign se1Err    = (curSt == LS_SE1);

  // cycles since reset, for the pin-to-flag check
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  p_se1_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd3 && $past(dpIn, 2) && $past(dmIn, 2)) |-> se1Err);

endmodule

// File: tb/bus_line_monitor_tb_top.sv
module bus_line_monitor_tb_top;
  import blm_pkg::*;

  localparam int FS_BIT = 4;
  localparam int LS_BIT = 16;
  localparam int CONN   = 20;
  localparam int RESETC = 100;
  localparam int IDLEC  = 300;
  localparam int RESUM  = 200;

  typedef enum int {E_CONN, E_EOP, E_KA, E_BRST, E_RESUME} evKind_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dpIn = 1'b0, dmIn = 1'b0, lowSpeed = 1'b0;
  logic [1:0] lineState;
  logic se1Err, connectEvt, eopEvt, keepAliveEvt, busResetEvt, suspendOut, resumeEvt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  evKind_t expQ[$];

  always #4 clk = ~clk;

  bus_line_monitor #(
    .FS_BIT_CYC(FS_BIT), .LS_BIT_CYC(LS_BIT), .CONN_CYC(CONN),
    .RESET_CYC(RESETC), .IDLE_CYC(IDLEC), .RESUME_CYC(RESUM), .KA_GAP_BITS(8)
  ) dut_i (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .lowSpeed(lowSpeed),
    .lineState(lineState), .se1Err(se1Err), .connectEvt(connectEvt),
    .eopEvt(eopEvt), .keepAliveEvt(keepAliveEvt), .busResetEvt(busResetEvt),
    .suspendOut(suspendOut), .resumeEvt(resumeEvt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectEvt(input evKind_t k);
    expQ.push_back(k);
  endtask

  // hold a line state for n clock cycles, drive on the falling edge
  task automatic drive(input lineSt_t s, input int n);
    @(negedge clk);
    case (s)
      LS_SE0: begin dpIn = 1'b0; dmIn = 1'b0; end
      LS_SE1: begin dpIn = 1'b1; dmIn = 1'b1; end
      LS_J:   begin dpIn = !lowSpeed; dmIn = lowSpeed; end
      default: begin dpIn = lowSpeed; dmIn = !lowSpeed; end
    endcase
    repeat (n - 1) @(negedge clk);
  endtask

  // scoreboard monitor: every pulse cycle must match the next expected event
  task automatic popCmp(input evKind_t got, input string req);
    if (expQ.size() == 0) begin
      check(1'b0, req, int'(got), -1);
    end else begin
      evKind_t e;
      e = expQ.pop_front();
      check(e == got, req, int'(got), int'(e));
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (connectEvt)   popCmp(E_CONN,   "R3 connect");
      if (eopEvt)       popCmp(E_EOP,    "R4 eop");
      if (keepAliveEvt) popCmp(E_KA,     "R5 keepalive");
      if (busResetEvt)  popCmp(E_BRST,   "R6 busreset");
      if (resumeEvt)    popCmp(E_RESUME, "R8 resume");
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(lineState == 2'b00, "R1 reset lineState", lineState, 0);
    check(suspendOut == 1'b0, "R7 reset suspend", suspendOut, 0);

    // R1 / R2 decoding at full speed
    drive(LS_J, 3);
    check(lineState == 2'b01 && dpIn, "R1 fs J", lineState, 1);
    drive(LS_K, 3);
    check(lineState == 2'b10, "R1 fs K", lineState, 2);
    drive(LS_SE1, 3);
    check(lineState == 2'b11, "R1 SE1", lineState, 3);
    check(se1Err == 1'b1, "R2 se1 flag", se1Err, 1);
    drive(LS_SE0, 3);
    check(se1Err == 1'b0, "R2 se1 clear", se1Err, 0);

    // R3 attach
    expectEvt(E_CONN);
    drive(LS_J, CONN + 10);

    // R4 packet tail at full speed
    drive(LS_K, FS_BIT); drive(LS_J, FS_BIT); drive(LS_K, 2*FS_BIT);
    drive(LS_J, FS_BIT);
    expectEvt(E_EOP);
    drive(LS_SE0, 2*FS_BIT); drive(LS_J, 20);

    // R5 bare eop at full speed is a plain eop
    drive(LS_J, 20*FS_BIT);
    expectEvt(E_EOP);
    drive(LS_SE0, 2*FS_BIT); drive(LS_J, 20);

    // R11 short SE0, and eop with truncated J
    drive(LS_SE0, 2); drive(LS_J, 20);
    drive(LS_SE0, 2*FS_BIT); drive(LS_J, 2); drive(LS_K, FS_BIT); drive(LS_J, 20);

    // R6 bus reset
    expectEvt(E_BRST);
    drive(LS_SE0, RESETC + 20); drive(LS_J, 4);

    // R7 suspend after inactivity
    drive(LS_J, IDLEC - 50);
    check(suspendOut == 1'b0, "R7 not yet suspended", suspendOut, 0);
    drive(LS_J, 80);
    check(suspendOut == 1'b1, "R7 suspended", suspendOut, 1);

    // R9 short K does not resume (its trailing eop is reported)
    drive(LS_K, 50);
    expectEvt(E_EOP);
    drive(LS_SE0, 2*FS_BIT); drive(LS_J, 40);
    check(suspendOut == 1'b1, "R9 still suspended", suspendOut, 1);

    // R8 resume
    drive(LS_K, RESUM + 20);
    expectEvt(E_RESUME);
    drive(LS_SE0, 2*FS_BIT); drive(LS_J, 10);
    check(suspendOut == 1'b0, "R8 awake", suspendOut, 0);

    // R6 reset out of suspend
    drive(LS_J, IDLEC + 30);
    check(suspendOut == 1'b1, "R7 suspended again", suspendOut, 1);
    expectEvt(E_BRST);
    drive(LS_SE0, RESETC + 10); drive(LS_J, 10);
    check(suspendOut == 1'b0, "R6 reset wakes", suspendOut, 0);

    // switch to low speed through a short SE0
    drive(LS_SE0, 3);
    @(negedge clk); lowSpeed = 1'b1;
    drive(LS_J, 3);
    check(lineState == 2'b01 && dmIn, "R1 ls J", lineState, 1);

    // R5 keep-alive at low speed
    drive(LS_J, 10*LS_BIT);
    expectEvt(E_KA);
    drive(LS_SE0, 2*LS_BIT); drive(LS_J, 2*LS_BIT);

    // R4 packet tail at low speed
    drive(LS_K, LS_BIT); drive(LS_J, LS_BIT); drive(LS_K, LS_BIT);
    expectEvt(E_EOP);
    drive(LS_SE0, 2*LS_BIT); drive(LS_J, 2*LS_BIT);

    drive(LS_J, 20);
    check(expQ.size() == 0, "R10 all events seen", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule